// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Hardware Walker

This block translates the virtual addresses issued by a CPU into physical addresses. It caches recent page translations in a small set-associative array. Each cached entry holds:

- a tag and a physical page number;
- a valid bit;
- use and dirty status;
- two permission bits: writable, and reachable from user mode.

Pages are 4 KB, so the low 12 address bits pass straight through to the physical address. A lookup that hits answers in the cycle after the request is accepted. It marks the entry as used, and for a write it also marks the entry as dirty.

On a miss, a built-in walker takes over while the CPU port stalls. The walker first picks a victim way in the addressed set. If that victim holds a live translation, the walker writes the victim's status back to its page-table word in memory. It then reads the page-table word of the requested page. That word sits at the page-table base plus the virtual page number. If the word is marked present, the walker loads it into the victim way and replays the lookup. If not, it reports a page fault.

Every completed access is checked against the entry's permission bits, using the access type and privilege level that the CPU supplies. A mismatch reports a protection fault.

Top module: `tlb_walker`

## Requirements
- R1: A successful translation returns `resp_paddr` = {entry page number, virtual address bits [11:0]}, with the 12 offset bits unchanged.
- R2: A request whose page is resident completes in the cycle after acceptance: `resp_valid` is seen one clock after the accepting edge. It makes no memory access.
- R3: A successful read sets the entry's use bit. A successful write sets both use and dirty. A faulting access changes neither. The state is observable in the status written back on eviction.
- R4: The set is the low 4 bits of the 20-bit virtual page number, and the remaining 16 bits are the tag. Two pages with the same set and different tags can be resident at once, one in each way.
- R5: On a miss, an invalid way in the set is always taken as the victim. When both ways are valid, the victim comes from a free-running counter.
- R6: When the victim is valid, the walker writes its page-table word before it reads the requested word. The write goes to `pt_base` + victim page number. The written word carries: present=1, the entry's page number and permission bits, and its current dirty and use bits.
- R7: The page-table read address is `pt_base` + the requested 20-bit virtual page number, with word addressing.
- R8: Page-table word layout:
  - bit 0: present;
  - bit 1: writable;
  - bit 2: user-accessible;
  - bit 3: dirty;
  - bit 4: use;
  - bits [23:12]: physical page number;
  - all other bits zero.

  A present word is loaded into the victim way, and the lookup is replayed. `resp_valid` follows two cycles after the read is acknowledged.
- R9: A word with bit 0 clear raises `fault_page` in the cycle after the read is acknowledged. Nothing is loaded, so the next access to that page walks again.
- R10: A write to a page whose writable bit is clear, or a user access to a page whose user bit is clear, raises `fault_perm` and not `fault_page`. Supervisor mode may read any present page.
- R11: `fault_page`, `fault_perm` and `resp_paddr` hold their values while no request is accepted. Both fault flags clear when the next request is accepted.
- R12: `req_ready` is low from the cycle after a missing request is accepted until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual byte address |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 24 | Physical address of last successful access |
| fault_page | output | 1 | Page not present (held) |
| fault_perm | output | 1 | Permission mismatch (held) |
| pt_base | input | 32 | Page-table base word address |
| mem_req | output | 1 | Page-table memory request |
| mem_we | output | 1 | 1 = write-back, 0 = read |
| mem_addr | output | 32 | Page-table word address |
| mem_wdata | output | 32 | Word written back |
| mem_ack | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Word read, valid with mem_ack |

## Verification
The bench first fills one set with two pages that share a set index but differ in tag, then returns to both. A design that ignored invalid ways during replacement would evict the first page, and the revisit would walk memory instead of answering in one cycle. A third page in the same set must then produce exactly one write-back, placed before the read. Every write-back word is compared with use and dirty history that the bench tracks from successful accesses alone. A design that marked pages on faulting accesses, or forgot to mark on writes, would write back wrong status bits. Absent pages are touched twice and permission-violating accesses are mixed into random traffic, so a design that cached absent pages, swapped the two fault flags or let them leak past the next request would be caught.

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 12,
  parameter int SETS  = 16,
  parameter int WAYS  = 2,
  parameter int PTE_W = 32,
  parameter int MA_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   req_user,
  output logic                   resp_valid,
  output logic [PPN_W+OFF_W-1:0] resp_paddr,
  output logic                   fault_page,
  output logic                   fault_perm,
  input  logic [MA_W-1:0]        pt_base,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [MA_W-1:0]        mem_addr,
  output logic [PTE_W-1:0]       mem_wdata,
  input  logic                   mem_ack,
  input  logic [PTE_W-1:0]       mem_rdata
);
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int TAG_W   = VPN_W - SET_W;
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int PPN_LSB = 12;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FETCH, S_RETRY} st_t;
  st_t st;

  logic [TAG_W-1:0] e_tag [SETS][WAYS];
  logic [PPN_W-1:0] e_ppn [SETS][WAYS];
  logic [WAYS-1:0]  e_v [SETS], e_d [SETS], e_u [SETS], e_w [SETS], e_usr [SETS];

  logic [VA_W-1:0]  h_va;
  logic             h_wr, h_usr;
  logic [WAY_W-1:0] h_vic, rnd;

  wire              fire   = req_valid && req_ready;
  wire [VA_W-1:0]   lk_va  = (st == S_IDLE) ? req_vaddr : h_va;
  wire              lk_wr  = (st == S_IDLE) ? req_write : h_wr;
  wire              lk_us  = (st == S_IDLE) ? req_user  : h_usr;
  wire [VPN_W-1:0]  lk_vpn = lk_va[VA_W-1:OFF_W];
  wire [SET_W-1:0]  lk_set = lk_vpn[SET_W-1:0];
  wire [TAG_W-1:0]  lk_tag = lk_vpn[VPN_W-1:SET_W];
  wire [VPN_W-1:0]  h_vpn  = h_va[VA_W-1:OFF_W];
  wire [SET_W-1:0]  h_set  = h_vpn[SET_W-1:0];

  logic             hit, vic_found;
  logic [WAY_W-1:0] hway, vic;

  always_comb begin
    hit = 1'b0;
    hway = '0;
    vic_found = 1'b0;
    vic = rnd;
    for (int w = 0; w < WAYS; w++) begin
      if (e_v[lk_set][w] && e_tag[lk_set][w] == lk_tag) begin
        hit = 1'b1;
        hway = WAY_W'(w);
      end
      if (!vic_found && !e_v[lk_set][w]) begin
        vic_found = 1'b1;
        vic = WAY_W'(w);
      end
    end
  end

  wire perm_bad    = (lk_wr && !e_w[lk_set][hway]) || (lk_us && !e_usr[lk_set][hway]);
  wire do_complete = (fire && hit) || (st == S_RETRY);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_WB) || (st == S_FETCH);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = pt_base + ((st == S_WB) ? MA_W'({e_tag[h_set][h_vic], h_set})
                                             : MA_W'(h_vpn));
  assign mem_wdata = PTE_W'({e_ppn[h_set][h_vic], 7'b0, e_u[h_set][h_vic], e_d[h_set][h_vic],
                             e_usr[h_set][h_vic], e_w[h_set][h_vic], 1'b1});

  logic unused_bits;
  assign unused_bits = ^{mem_rdata[PTE_W-1:PPN_LSB+PPN_W], mem_rdata[PPN_LSB-1:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rnd <= '0;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      fault_page <= 1'b0;
      fault_perm <= 1'b0;
      h_va <= '0;
      h_wr <= 1'b0;
      h_usr <= 1'b0;
      h_vic <= '0;
      for (int s = 0; s < SETS; s++) e_v[s] <= '0;
    end else begin
      rnd <= rnd + 1'b1;
      resp_valid <= 1'b0;
      if (do_complete) begin
        resp_valid <= 1'b1;
        if (perm_bad) fault_perm <= 1'b1;
        else begin
          resp_paddr <= {e_ppn[lk_set][hway], lk_va[OFF_W-1:0]};
          e_u[lk_set][hway] <= 1'b1;
          if (lk_wr) e_d[lk_set][hway] <= 1'b1;
        end
      end
      case (st)
        S_IDLE: if (fire) begin
          h_va <= req_vaddr;
          h_wr <= req_write;
          h_usr <= req_user;
          fault_page <= 1'b0;
          if (!(hit && perm_bad)) fault_perm <= 1'b0;
          if (!hit) begin
            h_vic <= vic;
            st <= e_v[lk_set][vic] ? S_WB : S_FETCH;
          end
        end
        S_WB: if (mem_ack) st <= S_FETCH;
        S_FETCH: if (mem_ack) begin
          if (mem_rdata[0]) begin
            e_v[h_set][h_vic]   <= 1'b1;
            e_tag[h_set][h_vic] <= h_vpn[VPN_W-1:SET_W];
            e_ppn[h_set][h_vic] <= mem_rdata[PPN_LSB +: PPN_W];
            e_w[h_set][h_vic]   <= mem_rdata[1];
            e_usr[h_set][h_vic] <= mem_rdata[2];
            e_d[h_set][h_vic]   <= mem_rdata[3];
            e_u[h_set][h_vic]   <= mem_rdata[4];
            st <= S_RETRY;
          end else begin
            fault_page <= 1'b1;
            resp_valid <= 1'b1;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !fault_page && !fault_perm) |-> resp_paddr[OFF_W-1:0] == h_va[OFF_W-1:0]);
  assert_refill_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && mem_rdata[0]) |=> !resp_valid ##1 resp_valid);
  assert_absent_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we && !mem_rdata[0]) |=> (resp_valid && fault_page));
  assert_fault_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_page && fault_perm));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(fault_page) && $stable(fault_perm) && $stable(resp_paddr)));
  assert_busy_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || !req_ready));
endmodule

// File: tb/tlb_walker_tb_top.sv
module tlb_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam int NPG = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic req_ready, resp_valid, fault_page, fault_perm;
  logic [23:0] resp_paddr;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  tlb_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .fault_page(fault_page),
    .fault_perm(fault_perm), .pt_base(BASE), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] mem [NPG];
  bit pt_v [NPG], pt_w [NPG], pt_u [NPG];
  logic [11:0] pt_ppn [NPG];
  bit succ_ever [NPG], wr_ever [NPG];
  int cur_vpn = 0, rd_now = 0, wb_now = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_word(int p);
    return {8'h0, pt_ppn[p], 7'h0, 1'b0, 1'b0, pt_u[p], pt_w[p], pt_v[p]};
  endfunction

  function automatic bit exp_perm_bad(int p, bit wr, bit us);
    return (wr && !pt_w[p]) || (us && !pt_u[p]);
  endfunction

  // page-table memory model and walker-traffic checks
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      int idx;
      idx = int'(mem_addr - BASE);
      if (mem_we) begin
        wb_now++;
        chk(idx >= 0 && idx < NPG, "R6", "write-back address in table", mem_addr, BASE);
        if (idx >= 0 && idx < NPG) begin
          chk(rd_now == 0, "R6", "write-back precedes read", rd_now, 0);
          chk(mem_wdata[0] == 1'b1 && mem_wdata[23:12] == pt_ppn[idx] &&
              mem_wdata[1] == pt_w[idx] && mem_wdata[2] == pt_u[idx], "R6",
              "write-back page number and permissions", mem_wdata, pte_word(idx));
          chk(mem_wdata[3] == wr_ever[idx], "R3", "written-back dirty", mem_wdata[3], wr_ever[idx]);
          chk(mem_wdata[4] == succ_ever[idx], "R3", "written-back use", mem_wdata[4], succ_ever[idx]);
          mem[idx] = mem_wdata;
        end
      end else begin
        rd_now++;
        chk(mem_addr == BASE + 32'(cur_vpn), "R7", "page-table read address", mem_addr, BASE + 32'(cur_vpn));
        mem_rdata = (idx >= 0 && idx < NPG) ? mem[idx] : 32'h0;
      end
      mem_ack = 1'b1;
    end
  end

  int lat = 0;

  task automatic access(input int vpn, input int off, input bit wr, input bit us);
    bit pb;
    @(negedge clk);
    cur_vpn = vpn; rd_now = 0; wb_now = 0;
    req_vaddr = {12'h0, 8'(vpn), 12'(off)};
    req_write = wr; req_user = us; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (!resp_valid) chk(req_ready == 1'b0, "R12", "stall during walk", req_ready, 0);
    while (!resp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    chk(resp_valid, "R8", "response arrives", resp_valid, 1);
    pb = exp_perm_bad(vpn, wr, us);
    if (!pt_v[vpn]) begin
      chk(fault_page && !fault_perm, "R9", "page fault flags", {fault_page, fault_perm}, 2'b10);
    end else if (pb) begin
      chk(fault_perm && !fault_page, "R10", "permission fault flags", {fault_page, fault_perm}, 2'b01);
    end else begin
      chk(!fault_page && !fault_perm, "R11", "flags clear on success", {fault_page, fault_perm}, 2'b00);
      chk(resp_paddr == {pt_ppn[vpn], 12'(off)}, "R1", "physical address", resp_paddr, {pt_ppn[vpn], 12'(off)});
      succ_ever[vpn] = 1'b1;
      if (wr) wr_ever[vpn] = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end (R12 stall), actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int p = 0; p < NPG; p++) begin
      pt_v[p] = (p % 7) != 3;
      pt_w[p] = 1'($urandom);
      pt_u[p] = 1'($urandom);
      pt_ppn[p] = 12'($urandom);
      succ_ever[p] = 0; wr_ever[p] = 0;
    end
    foreach (pt_v[p]) if (p == 1 || p == 17 || p == 33) begin
      pt_v[p] = 1; pt_w[p] = 1; pt_u[p] = 1; pt_ppn[p] = 12'hA00 + 12'(p);
    end
    pt_v[2] = 0;
    pt_v[4] = 1; pt_w[4] = 0; pt_u[4] = 0;
    for (int p = 0; p < NPG; p++) mem[p] = pte_word(p);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req, "R12", "reset: ready, idle", {req_ready, resp_valid, mem_req}, 3'b100);
    chk(!fault_page && !fault_perm, "R11", "reset: no faults", {fault_page, fault_perm}, 0);

    access(1, 12'h123, 0, 1);
    chk(lat > 1 && rd_now == 1 && wb_now == 0, "R5", "cold miss uses invalid way, no write-back", {lat[15:0], rd_now[7:0], wb_now[7:0]}, 1);
    access(17, 12'hABC, 1, 0);
    chk(rd_now == 1 && wb_now == 0, "R5", "second tag fills the other invalid way", wb_now, 0);
    access(1, 12'hFFF, 0, 0);
    chk(lat == 1 && rd_now == 0, "R2", "revisit hits in one cycle", lat, 1);
    access(17, 12'h000, 0, 1);
    chk(lat == 1 && rd_now == 0, "R4", "same set, other tag still resident", lat, 1);
    access(33, 12'h555, 0, 0);
    chk(wb_now == 1 && rd_now == 1, "R6", "full set miss: one write-back then read", {wb_now[7:0], rd_now[7:0]}, 16'h0101);

    access(2, 12'h010, 0, 0);
    access(2, 12'h020, 0, 0);
    chk(rd_now == 1, "R9", "absent page not cached, walks again", rd_now, 1);
    repeat (5) @(negedge clk);
    chk(fault_page, "R11", "page fault held while idle", fault_page, 1);

    access(4, 12'h040, 0, 1);
    access(4, 12'h044, 1, 0);
    repeat (4) @(negedge clk);
    chk(fault_perm, "R11", "permission fault held while idle", fault_perm, 1);
    access(4, 12'h048, 0, 0);
    chk(!fault_perm, "R10", "supervisor read of protected page allowed", fault_perm, 0);

    for (int i = 0; i < 600; i++)
      access(int'($urandom_range(0, NPG-1)), int'($urandom_range(0, 4095)), 1'($urandom), 1'($urandom));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule